// File: doc/BRIEF.md
# Wide Vector Register File with Upper-Half State Tracking

This block holds sixteen 256-bit vector registers. Narrow (128-bit) code sees only bits 127:0 of each register. Each instruction on the single issue port carries one of five operation kinds:

- a narrow write that keeps the upper half (the compatibility form);
- a narrow write that zeroes the upper half;
- a full-width write;
- a clear of every upper half;
- a clear of every register.

A small tracker records whether any upper half may hold live data. When compatibility-form code meets live upper halves, the tracker moves all upper halves into a side scratchpad. It does this once, in a single burst. When wide code comes back, it moves them back, again in one burst. No per-write merge takes place.

While a burst runs, the block raises a stall output. Each burst moves one register per cycle, so the stall lasts sixteen cycles. The instruction that caused the burst is held inside the block. It commits at the clock edge that ends the stall. Two counters record the bursts: one counts moves to the scratchpad, the other counts moves back.

The two read ports are registered. They always return the architectural 256-bit value, whether the upper half currently sits in the register array or in the scratchpad.

Top module: `vrf_upper_tracker`

## Requirements
- R1: There are 16 registers of 256 bits. The register chosen by `rdN_idx` at a clock edge appears on `rdN_data` after that edge, with one cycle of latency. The value read is the one before any write at that same edge. The narrow view of a register is its bits 127:0.
- R2: Kind code 0 (compatibility narrow write) replaces bits 127:0 of the destination. It leaves bits 255:128 unchanged.
- R3: Kind code 1 (zeroing narrow write) replaces bits 127:0 of the destination and sets bits 255:128 to zero.
- R4: Kind code 2 (wide write) replaces all 256 bits of the destination. It moves the tracker from clean to dirty even when the written upper bits are zero.
- R5: Kind code 3 clears bits 255:128 of all 16 registers. Kind code 4 clears all 256 bits of all 16 registers. Both commit at the clock edge that accepts them, never stall, and leave the tracker clean.
- R6: In the clean state, any mix of kind codes 0, 1 and 2 runs without a stall.
- R7: In the dirty state, kind codes 1 and 2 run without a stall. Kind code 0 raises `stall` for exactly 16 cycles while the upper halves move to the scratchpad; the tracker then becomes saved. The held instruction's result can be read in the first cycle after the stall.
- R8: In the saved state, kind code 0 runs without a stall. Kind code 1 or 2 raises `stall` for exactly 16 cycles while the upper halves return; the held instruction then commits and the tracker becomes dirty.
- R9: `cnt_save` counts moves to the scratchpad and `cnt_rest` counts moves back. Each counter steps by one at the edge that ends the matching stall, and the two never step at the same edge.
- R10: Kind code 3 or 4 in the saved state causes no stall. It discards the scratchpad and leaves every upper half reading zero (and every register reading zero for kind code 4). Later kind code 0 then runs without a stall.
- R11: In the saved state, the read ports return the preserved upper halves.
- R12: Reset (synchronous, active high) zeroes all registers and both counters, clears the stall, and makes the tracker clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction present; accepted at an edge where `stall` is low |
| iss_kind | input | 3 | Operation kind code 0..4 |
| iss_dst | input | 4 | Destination register index |
| iss_data | input | 256 | Write data; bits 127:0 used by narrow kinds |
| stall | output | 1 | High while a scratchpad move runs; issue is ignored |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_data | output | 256 | Read port 0 data, one cycle after the index |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_data | output | 256 | Read port 1 data, one cycle after the index |
| cnt_save | output | 16 | Count of moves to the scratchpad |
| cnt_rest | output | 16 | Count of moves back from the scratchpad |

## Verification
The bench targets the edges between tracker states, and counts stall cycles exactly:

- A compatibility write in the dirty state, and a wide or zeroing write in the saved state. A design with an off-by-one copy loop would stall for 15 or 17 cycles. One that dropped the held instruction would read back stale data.
- Reads taken while the upper halves sit in the scratchpad. A design that read only the register array would return zeros there.
- Clear operations issued in the saved state. A wrong design would restore first and stall, or would resurrect old upper data later.
- Zeroing narrow writes over live upper data, and full clears, checked with every register read back. Wrong merge rules show up as corrupted halves.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [2:0] {
    K_LEG  = 3'd0,
    K_P128 = 3'd1,
    K_P256 = 3'd2,
    K_ZUP  = 3'd3,
    K_ZALL = 3'd4
  } op_kind_t;

  typedef enum logic [2:0] {
    S_CLEAN     = 3'd0,
    S_DIRTY     = 3'd1,
    S_PARKED    = 3'd2,
    S_SAVING    = 3'd3,
    S_RESTORING = 3'd4
  } trk_state_t;
endpackage

// File: rtl/vrf_lower_bank.sv
// Holds bits LW-1:0 of every register; two registered read ports.
module vrf_lower_bank #(
  parameter int NREGS = 16,
  parameter int LW    = 128,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [LW-1:0] wdata,
  input  logic          clr_all,
  input  logic [IW-1:0] ra0,
  input  logic [IW-1:0] ra1,
  output logic [LW-1:0] rd0,
  output logic [LW-1:0] rd1
);
  logic [LW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0 <= '0;
      rd1 <= '0;
    end else begin
      rd0 <= mem[ra0];
      rd1 <= mem[ra1];
    end
  end
endmodule

// File: rtl/vrf_upper_bank.sv
// Holds the upper halves, the scratchpad and a per-register location bit
// telling the read ports where the live upper half currently sits.
module vrf_upper_bank #(
  parameter int NREGS = 16,
  parameter int UW    = 128,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [UW-1:0] wdata,
  input  logic          clr_all,
  input  logic          cp_save,
  input  logic          cp_rest,
  input  logic [IW-1:0] cp_idx,
  input  logic [IW-1:0] ra0,
  input  logic [IW-1:0] ra1,
  output logic [UW-1:0] rd0,
  output logic [UW-1:0] rd1
);
  logic [UW-1:0] upper   [NREGS];
  logic [UW-1:0] scratch [NREGS];
  logic [NREGS-1:0] parked;

  // Scratchpad: one write port, no reset, suited to a RAM.
  always_ff @(posedge clk) begin
    if (cp_save) scratch[cp_idx] <= upper[cp_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) upper[i] <= '0;
      parked <= '0;
    end else begin
      if (cp_save) begin
        upper[cp_idx]  <= '0;
        parked[cp_idx] <= 1'b1;
      end
      if (cp_rest) begin
        upper[cp_idx]  <= scratch[cp_idx];
        parked[cp_idx] <= 1'b0;
      end
      if (clr_all) begin
        for (int i = 0; i < NREGS; i++) upper[i] <= '0;
        parked <= '0;
      end else if (we) begin
        upper[widx] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0 <= '0;
      rd1 <= '0;
    end else begin
      rd0 <= parked[ra0] ? scratch[ra0] : upper[ra0];
      rd1 <= parked[ra1] ? scratch[ra1] : upper[ra1];
    end
  end
endmodule

// File: rtl/vrf_mode_fsm.sv
// Tracks upper-half liveness, sequences scratchpad bursts, holds the
// triggering instruction and counts the penalised transitions.
module vrf_mode_fsm
  import vrf_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int VW    = 256,
  parameter int CW    = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [2:0]    iss_kind,
  input  logic [IW-1:0] iss_dst,
  input  logic [VW-1:0] iss_data,
  output logic          stall,
  output logic          cm_valid,
  output op_kind_t      cm_kind,
  output logic [IW-1:0] cm_dst,
  output logic [VW-1:0] cm_data,
  output logic          cp_save,
  output logic          cp_rest,
  output logic [IW-1:0] cp_idx,
  output logic [CW-1:0] cnt_save,
  output logic [CW-1:0] cnt_rest
);
  trk_state_t    state;
  logic [IW-1:0] ptr;
  op_kind_t      pend_kind;
  logic [IW-1:0] pend_dst;
  logic [VW-1:0] pend_data;
  op_kind_t      kind;
  logic          busy, last, direct, start_save, start_rest;

  assign kind  = op_kind_t'(iss_kind);
  assign busy  = (state == S_SAVING) || (state == S_RESTORING);
  assign last  = (ptr == IW'(NREGS - 1));
  assign stall = busy;

  always_comb begin
    direct     = 1'b0;
    start_save = 1'b0;
    start_rest = 1'b0;
    if (!busy && iss_valid) begin
      case (kind)
        K_LEG:  if (state == S_DIRTY) start_save = 1'b1; else direct = 1'b1;
        K_P128,
        K_P256: if (state == S_PARKED) start_rest = 1'b1; else direct = 1'b1;
        K_ZUP,
        K_ZALL: direct = 1'b1;
        default: ;
      endcase
    end
  end

  assign cm_valid = direct || (busy && last);
  assign cm_kind  = direct ? kind     : pend_kind;
  assign cm_dst   = direct ? iss_dst  : pend_dst;
  assign cm_data  = direct ? iss_data : pend_data;
  assign cp_save  = (state == S_SAVING);
  assign cp_rest  = (state == S_RESTORING);
  assign cp_idx   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_CLEAN;
      ptr       <= '0;
      pend_kind <= K_LEG;
      pend_dst  <= '0;
      pend_data <= '0;
      cnt_save  <= '0;
      cnt_rest  <= '0;
    end else begin
      case (state)
        S_SAVING, S_RESTORING: begin
          ptr <= ptr + 1'b1;
          if (last) begin
            ptr <= '0;
            if (state == S_SAVING) begin
              state    <= S_PARKED;
              cnt_save <= cnt_save + CW'(1);
            end else begin
              state    <= S_DIRTY;
              cnt_rest <= cnt_rest + CW'(1);
            end
          end
        end
        default: begin
          if (start_save || start_rest) begin
            pend_kind <= kind;
            pend_dst  <= iss_dst;
            pend_data <= iss_data;
            ptr       <= '0;
            state     <= start_save ? S_SAVING : S_RESTORING;
          end else if (direct) begin
            case (kind)
              K_P256:        state <= S_DIRTY;
              K_ZUP, K_ZALL: state <= S_CLEAN;
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vrf_upper_tracker.sv
module vrf_upper_tracker
  import vrf_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int VW    = 256,
  parameter int CW    = 16,
  localparam int IW   = $clog2(NREGS),
  localparam int LW   = VW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [2:0]    iss_kind,
  input  logic [IW-1:0] iss_dst,
  input  logic [VW-1:0] iss_data,
  output logic          stall,
  input  logic [IW-1:0] rd0_idx,
  output logic [VW-1:0] rd0_data,
  input  logic [IW-1:0] rd1_idx,
  output logic [VW-1:0] rd1_data,
  output logic [CW-1:0] cnt_save,
  output logic [CW-1:0] cnt_rest
);
  logic          cm_valid, cp_save, cp_rest;
  op_kind_t      cm_kind;
  logic [IW-1:0] cm_dst, cp_idx;
  logic [VW-1:0] cm_data;
  logic          lo_we, lo_clr, up_we, up_clr;
  logic [LW-1:0] up_wd, lo_rd0, lo_rd1, up_rd0, up_rd1;

  vrf_mode_fsm #(.NREGS(NREGS), .VW(VW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dst(iss_dst), .iss_data(iss_data),
    .stall(stall),
    .cm_valid(cm_valid), .cm_kind(cm_kind), .cm_dst(cm_dst), .cm_data(cm_data),
    .cp_save(cp_save), .cp_rest(cp_rest), .cp_idx(cp_idx),
    .cnt_save(cnt_save), .cnt_rest(cnt_rest)
  );

  assign lo_we  = cm_valid && (cm_kind == K_LEG || cm_kind == K_P128 || cm_kind == K_P256);
  assign lo_clr = cm_valid && (cm_kind == K_ZALL);
  assign up_we  = cm_valid && (cm_kind == K_P128 || cm_kind == K_P256);
  assign up_clr = cm_valid && (cm_kind == K_ZUP || cm_kind == K_ZALL);
  assign up_wd  = (cm_kind == K_P256) ? cm_data[VW-1:LW] : '0;

  vrf_lower_bank #(.NREGS(NREGS), .LW(LW)) u_lo (
    .clk(clk), .rst(rst),
    .we(lo_we), .widx(cm_dst), .wdata(cm_data[LW-1:0]), .clr_all(lo_clr),
    .ra0(rd0_idx), .ra1(rd1_idx), .rd0(lo_rd0), .rd1(lo_rd1)
  );

  vrf_upper_bank #(.NREGS(NREGS), .UW(LW)) u_up (
    .clk(clk), .rst(rst),
    .we(up_we), .widx(cm_dst), .wdata(up_wd), .clr_all(up_clr),
    .cp_save(cp_save), .cp_rest(cp_rest), .cp_idx(cp_idx),
    .ra0(rd0_idx), .ra1(rd1_idx), .rd0(up_rd0), .rd1(up_rd1)
  );

  assign rd0_data = {up_rd0, lo_rd0};
  assign rd1_data = {up_rd1, lo_rd1};
endmodule

// File: rtl/vrf_tracker_chk.sv
module vrf_tracker_chk #(
  parameter int NREGS = 16,
  parameter int CW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_valid,
  input logic [2:0]    iss_kind,
  input logic          stall,
  input logic [CW-1:0] cnt_save,
  input logic [CW-1:0] cnt_rest
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (rst)        run <= '0;
    else if (stall) run <= run + 8'd1;
    else            run <= '0;
  end

  // R7
  stall_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> (run == 8'(NREGS)));

  // R8
  stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run <= 8'(NREGS));

  // R9
  save_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_save) |-> ($fell(stall) && cnt_save == $past(cnt_save) + CW'(1)));

  // R9
  rest_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_rest) |-> ($fell(stall) && $stable(cnt_save)));

  // R5
  zero_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !stall && (iss_kind == 3'd3 || iss_kind == 3'd4)) |=> !stall);

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_save == '0 && cnt_rest == '0 && !stall));
endmodule

bind vrf_upper_tracker vrf_tracker_chk #(.NREGS(NREGS), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
  .stall(stall), .cnt_save(cnt_save), .cnt_rest(cnt_rest)
);

// File: tb/sim_vrf_upper_tracker.sv
module sim_vrf_upper_tracker;
  localparam int NREGS = 16;
  localparam int VW    = 256;
  localparam int LW    = 128;
  localparam int IW    = 4;
  localparam int CW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic [2:0]    iss_kind = '0;
  logic [IW-1:0] iss_dst = '0;
  logic [VW-1:0] iss_data = '0;
  logic          stall;
  logic [IW-1:0] rd0_idx = '0, rd1_idx = '0;
  logic [VW-1:0] rd0_data, rd1_data;
  logic [CW-1:0] cnt_save, cnt_rest;

  always #5 clk = ~clk;

  vrf_upper_tracker #(.NREGS(NREGS), .VW(VW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_dst(iss_dst), .iss_data(iss_data), .stall(stall),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .cnt_save(cnt_save), .cnt_rest(cnt_rest)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           due;
    int           port;
    int           idx;
    logic [VW-1:0] exp;
    string        tag;
  } rd_item_t;

  rd_item_t      sq[$];
  rd_item_t      it;
  logic [VW-1:0] got;

  // Bench model built from the requirements
  logic [VW-1:0] mdl [NREGS];
  int            mode;      // 0 clean, 1 dirty, 2 saved
  int            exp_sv, exp_rs;

  // Scoreboard monitor
  always @(negedge clk) begin
    while (sq.size() > 0 && sq[0].due <= cyc) begin
      it  = sq.pop_front();
      got = (it.port == 0) ? rd0_data : rd1_data;
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s reg%0d port%0d got=%h exp=%h", it.tag, it.idx, it.port, got, it.exp);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mk(input int s);
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = (s * 32'h01000193) ^ (k * 32'h9E3779B9) ^ 32'h5A5A0000;
    return v;
  endfunction

  task automatic rd2(input int a, input int b, input string tag);
    rd_item_t x;
    rd0_idx = IW'(a);
    rd1_idx = IW'(b);
    x.due = cyc + 1; x.port = 0; x.idx = a; x.exp = mdl[a]; x.tag = tag;
    sq.push_back(x);
    x.port = 1; x.idx = b; x.exp = mdl[b];
    sq.push_back(x);
    @(negedge clk);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < NREGS; i += 2) rd2(i, i + 1, tag);
  endtask

  task automatic issue(input int kind, input int dst, input logic [VW-1:0] d, input string tag);
    int exp_st;
    int n;
    exp_st = ((mode == 1 && kind == 0) || (mode == 2 && (kind == 1 || kind == 2))) ? NREGS : 0;
    iss_valid = 1'b1;
    iss_kind  = 3'(kind);
    iss_dst   = IW'(dst);
    iss_data  = d;
    @(negedge clk);
    iss_valid = 1'b0;
    n = 0;
    while (stall && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " stall cycles"}, 64'(n), 64'(exp_st));
    case (kind)
      0: begin
        mdl[dst][LW-1:0] = d[LW-1:0];
        if (mode == 1) begin mode = 2; exp_sv++; end
      end
      1: begin
        mdl[dst] = {{LW{1'b0}}, d[LW-1:0]};
        if (mode == 2) begin mode = 1; exp_rs++; end
      end
      2: begin
        mdl[dst] = d;
        if (mode == 2) exp_rs++;
        mode = 1;
      end
      3: begin
        for (int i = 0; i < NREGS; i++) mdl[i][VW-1:LW] = '0;
        mode = 0;
      end
      default: begin
        for (int i = 0; i < NREGS; i++) mdl[i] = '0;
        mode = 0;
      end
    endcase
    chk({tag, " cnt_save (R9)"}, 64'(cnt_save), 64'(exp_sv));
    chk({tag, " cnt_rest (R9)"}, 64'(cnt_rest), 64'(exp_rs));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) mdl[i] = '0;
    mode = 0; exp_sv = 0; exp_rs = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 stall after reset", 64'(stall), 64'd0);
    chk("R12 cnt_save after reset", 64'(cnt_save), 64'd0);
    chk("R12 cnt_rest after reset", 64'(cnt_rest), 64'd0);
    rd_all("R12 reset contents");

    // R6 clean state, mixed narrow kinds
    issue(0, 1, mk(1), "R6 compat write clean");
    issue(1, 2, mk(2), "R6 zeroing write clean");
    issue(0, 2, mk(3), "R6 compat write clean");
    rd2(1, 2, "R1 R6 narrow view");

    // R4 wide writes enter dirty
    issue(2, 3, mk(4), "R4 wide write clean");
    issue(2, 5, mk(5), "R4 wide write dirty");
    issue(2, 4, mk(6), "R7 wide write dirty");
    issue(1, 4, mk(7), "R3 zeroing write over live upper");
    rd2(3, 4, "R3 R4 contents");

    // R7 dirty -> saved
    issue(0, 5, mk(8), "R7 compat write in dirty");
    rd2(5, 3, "R2 R11 merged value and parked upper");
    issue(0, 6, mk(9), "R8 compat write in saved");
    rd_all("R11 saved-state reads");

    // R8 saved -> dirty through wide write
    issue(2, 7, mk(10), "R8 wide write in saved");
    rd_all("R8 restored contents");

    // R10 clear-upper discards parked data
    issue(0, 8, mk(11), "R7 second save");
    issue(3, 0, '0, "R10 clear-upper in saved");
    rd_all("R10 uppers cleared");
    issue(0, 9, mk(12), "R10 compat write after discard");

    // R5 clear-all
    issue(2, 10, mk(13), "R4 wide write before clear-all");
    issue(4, 0, '0, "R5 clear-all in dirty");
    rd_all("R5 all registers zero");
    issue(0, 11, mk(14), "R5 compat after clear-all");

    // R8 zeroing narrow write ends saved state
    issue(2, 12, mk(15), "R4 wide write");
    issue(2, 15, mk(16), "R4 wide write r15");
    issue(0, 13, mk(17), "R7 third save");
    issue(1, 15, mk(18), "R8 zeroing write in saved");
    rd_all("R8 R3 contents after restore");

    // R10 clear-all in saved state
    issue(0, 14, mk(19), "R7 fourth save");
    issue(4, 0, '0, "R10 clear-all in saved");
    rd_all("R10 clear-all contents");
    issue(0, 1, mk(20), "R10 compat after clear-all");

    // R5 clear-upper in dirty
    issue(2, 2, mk(21), "R4 wide write");
    issue(3, 0, '0, "R5 clear-upper in dirty");
    issue(0, 3, mk(22), "R5 compat after clear-upper");
    rd_all("R5 final contents");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule